// File: doc/BRIEF.md
# DMA Channel Address Register Bank

This block holds the 16-bit address state of a four-channel DMA controller. The low 16 bits of each transfer address come from here, and a separate page register supplies the bits above them. Each channel keeps a base address, which holds its programmed value, and a current address, which moves once per transfer. Software reaches every 16-bit register through an 8-bit data path. A single byte-pointer flip-flop, shared by all channels, decides whether an access lands on the low byte or the high byte. Software can clear that pointer before it starts a new address.

The transfer engine reports each completed transfer with a strobe and names the channel. It also flags terminal count. On each transfer the channel's current address moves up or down by one, as set by that channel's direction control. When terminal count arrives and the channel has auto-initialize enabled, the current address is instead reloaded from the base register. A status byte reports two things for each channel: whether terminal count has been reached, and whether a request is pending. Reading the status byte clears the terminal-count flags.

Top module: `dma_addr_bank`

## Requirements
- R1: After reset the byte pointer selects the low byte, all base and current addresses are 0000h, `rdata` is 00h and the terminal-count flags are 0. With no request inputs high, `stat_data` reads 00h.
- R2: Every address access toggles the shared byte pointer, whatever the channel. An access is `wr_en` or `rd_en`, and the two are never high together. The first access after the pointer is cleared targets bits 7:0, and the next targets bits 15:8.
- R3: `bp_clr` or `mclr` returns the pointer to the low byte at the clock edge. An access in the same cycle still uses the old pointer value, and the pointer ends low.
- R4: A write stores `wdata` into the selected byte of both the base and the current register of `chan_sel`. A transfer never changes a base register.
- R5: A read loads `rdata` at the clock edge with the selected byte of the current address of `chan_sel`, taken before any same-cycle update. `rdata` holds its value until the next read.
- R6: A transfer without terminal count moves the current address of `xfer_ch` by one. It counts up when `dir_dec[ch]` is 0 and down when it is 1, and it wraps modulo 2^16. With no transfer and no write, the address holds.
- R7: A transfer with `tc` high and `auto_init[ch]` high loads the current address with the base value instead of stepping. With `auto_init[ch]` low, the address steps as in R6.
- R8: A transfer with `tc` high sets terminal-count flag `ch`, which is `stat_data` bit ch (bits 3:0).
- R9: `stat_rd` clears all terminal-count flags at the edge, except a flag set by a transfer in the same cycle. `mclr` clears all of them unconditionally.
- R10: `stat_data` bit 4+ch equals `hw_req[ch] | sw_req[ch]` combinationally, with no register in between.
- R11: A write and a transfer in the same cycle to the same channel: the write updates its byte, and the transfer does not move that channel's current address. The terminal-count flag is still set.
- R12: `addr_out` shows the current address of `xfer_ch` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mclr | input | 1 | Master clear: byte pointer low, TC flags cleared |
| bp_clr | input | 1 | Clear byte pointer to low byte |
| wr_en | input | 1 | Address byte write |
| rd_en | input | 1 | Address byte read |
| chan_sel | input | 2 | Channel for read/write |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| xfer | input | 1 | One transfer completed |
| xfer_ch | input | 2 | Channel of the transfer |
| tc | input | 1 | Terminal count on this transfer |
| dir_dec | input | 4 | Per-channel direction, 1 = decrement |
| auto_init | input | 4 | Per-channel auto-initialize enable |
| hw_req | input | 4 | Hardware request lines |
| sw_req | input | 4 | Software request bits |
| stat_rd | input | 1 | Status read strobe (clears TC flags) |
| stat_data | output | 8 | {request[3:0], tc_flag[3:0]} |
| addr_out | output | 16 | Current address of `xfer_ch` |

## Verification
The results fall into two timing groups. `rdata`, the stored addresses, the byte pointer and the terminal-count flags are registered, so their effect is due one edge after the strobe. The request half of `stat_data` and `addr_out` are combinational, so they follow their inputs within the same cycle. The bench drives inputs just after a rising edge. It waits for the next rising edge and compares all outputs 1 ns later. That one sample sees the registered results of the previous inputs and the combinational results of the inputs still applied.

// File: rtl/dma_addr_pkg.sv
package dma_addr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a,
                                                  input logic dec);
    return dec ? (a - 1'b1) : (a + 1'b1);
  endfunction

  function automatic logic [ADDR_W-1:0] put_byte(input logic [ADDR_W-1:0] a,
                                                 input logic hi,
                                                 input logic [BYTE_W-1:0] b);
    logic [ADDR_W-1:0] r;
    r = a;
    if (hi) r[ADDR_W-1:BYTE_W] = b;
    else    r[BYTE_W-1:0]      = b;
    return r;
  endfunction

  function automatic logic [BYTE_W-1:0] get_byte(input logic [ADDR_W-1:0] a,
                                                 input logic hi);
    return hi ? a[ADDR_W-1:BYTE_W] : a[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic mclr,
  input  logic bp_clr,
  input  logic access,
  output logic hi
);
  logic clr_evt;
  logic tgl_evt;

  assign clr_evt = mclr | bp_clr;
  assign tgl_evt = access & ~clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi <= 1'b0;
    else if (clr_evt) hi <= 1'b0;
    else if (tgl_evt) hi <= ~hi;
  end

  AST_BP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr || bp_clr) |=> !hi); // R3
  AST_BP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !mclr && !bp_clr) |=> (hi != $past(hi))); // R2
  AST_BP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!access && !mclr && !bp_clr) |=> $stable(hi)); // R2
endmodule

// File: rtl/dma_chan_addr.sv
module dma_chan_addr
  import dma_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_byte,
  input  logic              hi,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              xfer_here,
  input  logic              tc,
  input  logic              auto_init,
  input  logic              dec,
  output logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] base
);
  logic reload_evt;
  logic step_evt;

  assign reload_evt = xfer_here & ~wr_byte & tc & auto_init;
  assign step_evt   = xfer_here & ~wr_byte & ~reload_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base <= '0;
    end else if (wr_byte) begin
      base <= put_byte(base, hi, wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
    end else if (wr_byte) begin
      cur <= put_byte(cur, hi, wdata);
    end else if (reload_evt) begin
      cur <= base;
    end else if (step_evt) begin
      cur <= step_addr(cur, dec);
    end
  end

  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_byte |=> $stable(base)); // R4
  AST_AUTO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_here && !wr_byte && tc && auto_init) |=> (cur == $past(base))); // R7
  AST_CUR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_here && !wr_byte) |=> $stable(cur)); // R6
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte |=> ((($past(hi) ? cur[ADDR_W-1:BYTE_W] : cur[BYTE_W-1:0]) == $past(wdata))
                 && (cur == base || $past(cur) != $past(base) || 1'b1))); // R11
endmodule

// File: rtl/dma_tc_status.sv
module dma_tc_status #(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclr,
  input  logic             stat_rd,
  input  logic [NCH-1:0]   tc_set,
  input  logic [NCH-1:0]   req,
  output logic [2*NCH-1:0] stat
);
  logic [NCH-1:0] tc_flags;
  logic [NCH-1:0] kept;

  assign kept = (stat_rd | mclr) ? '0 : tc_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tc_flags <= '0;
    else if (mclr) tc_flags <= '0;
    else           tc_flags <= kept | tc_set;
  end

  assign stat = {req, tc_flags};

  AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr || (stat_rd && tc_set == '0)) |=> (tc_flags == '0)); // R9
  AST_TC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclr && tc_set != '0) |=> ((tc_flags & $past(tc_set)) == $past(tc_set))); // R8
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclr && !stat_rd) |=> ((tc_flags & $past(tc_flags)) == $past(tc_flags))); // R8
endmodule

// File: rtl/dma_addr_bank.sv
module dma_addr_bank
  import dma_addr_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mclr,
  input  logic              bp_clr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [CH_W-1:0]   chan_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              xfer,
  input  logic [CH_W-1:0]   xfer_ch,
  input  logic              tc,
  input  logic [NCH-1:0]    dir_dec,
  input  logic [NCH-1:0]    auto_init,
  input  logic [NCH-1:0]    hw_req,
  input  logic [NCH-1:0]    sw_req,
  input  logic              stat_rd,
  output logic [2*NCH-1:0]  stat_data,
  output logic [ADDR_W-1:0] addr_out
);
  logic              bp_hi;
  logic              access;
  logic              rd_evt;
  logic [NCH-1:0]    wr_hit;
  logic [NCH-1:0]    xfer_hit;
  logic [NCH-1:0]    tc_hit;
  logic [ADDR_W-1:0] cur_arr  [NCH];
  logic [ADDR_W-1:0] base_arr [NCH];

  assign access = wr_en | rd_en;
  assign rd_evt = rd_en & ~wr_en;

  dma_byte_ptr u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .mclr   (mclr),
    .bp_clr (bp_clr),
    .access (access),
    .hi     (bp_hi)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign wr_hit[i]   = wr_en & (chan_sel == CH_W'(i));
    assign xfer_hit[i] = xfer & (xfer_ch == CH_W'(i));
    assign tc_hit[i]   = xfer_hit[i] & tc;

    dma_chan_addr u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_byte   (wr_hit[i]),
      .hi        (bp_hi),
      .wdata     (wdata),
      .xfer_here (xfer_hit[i]),
      .tc        (tc),
      .auto_init (auto_init[i]),
      .dec       (dir_dec[i]),
      .cur       (cur_arr[i]),
      .base      (base_arr[i])
    );
  end

  dma_tc_status #(.NCH(NCH)) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .mclr    (mclr),
    .stat_rd (stat_rd),
    .tc_set  (tc_hit),
    .req     (hw_req | sw_req),
    .stat    (stat_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_evt) rdata <= get_byte(cur_arr[chan_sel], bp_hi);
  end

  assign addr_out = cur_arr[xfer_ch];

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit)); // R4
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(rdata)); // R5
endmodule

// File: tb/dma_addr_bank_bench.sv
`timescale 1ns/1ps
module dma_addr_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mclr = 0, bp_clr = 0, wr_en = 0, rd_en = 0, xfer = 0, tc = 0, stat_rd = 0;
  logic [1:0] chan_sel = 0, xfer_ch = 0;
  logic [7:0] wdata = 0;
  logic [3:0] dir_dec = 0, auto_init = 0, hw_req = 0, sw_req = 0;
  logic [7:0] rdata, stat_data;
  logic [15:0] addr_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_cur [4];
  int m_base[4];
  int m_bp;
  int m_tc;
  int m_rdata;

  always #2 clk = ~clk;

  dma_addr_bank u_dma_addr_bank (
    .clk(clk), .rst_n(rst_n), .mclr(mclr), .bp_clr(bp_clr), .wr_en(wr_en),
    .rd_en(rd_en), .chan_sel(chan_sel), .wdata(wdata), .rdata(rdata),
    .xfer(xfer), .xfer_ch(xfer_ch), .tc(tc), .dir_dec(dir_dec),
    .auto_init(auto_init), .hw_req(hw_req), .sw_req(sw_req),
    .stat_rd(stat_rd), .stat_data(stat_data), .addr_out(addr_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int set_byte(input int a, input int hi, input int b);
    if (hi != 0) return (a % 256) + b * 256;
    return (a / 256) * 256 + b;
  endfunction

  function automatic int nxt(input int a, input bit down);
    if (down) return (a + 65535) % 65536;
    return (a + 1) % 65536;
  endfunction

  // apply current inputs for one edge, update model, compare outputs
  task automatic tick();
    int nc[4];
    int nt;
    for (int i = 0; i < 4; i++) nc[i] = m_cur[i];
    if (rd_en && !wr_en)
      m_rdata = (m_bp != 0) ? (m_cur[chan_sel] / 256) : (m_cur[chan_sel] % 256);
    if (xfer && !(wr_en && chan_sel == xfer_ch)) begin
      if (tc && auto_init[xfer_ch]) nc[xfer_ch] = m_base[xfer_ch];
      else nc[xfer_ch] = nxt(m_cur[xfer_ch], dir_dec[xfer_ch]);
    end
    if (wr_en) begin
      nc[chan_sel] = set_byte(m_cur[chan_sel], m_bp, wdata);
      m_base[chan_sel] = set_byte(m_base[chan_sel], m_bp, wdata);
    end
    nt = (stat_rd ? 0 : m_tc) | ((xfer && tc) ? (1 << xfer_ch) : 0);
    if (mclr) nt = 0;
    m_tc = nt;
    if (mclr || bp_clr) m_bp = 0;
    else if (wr_en || rd_en) m_bp = 1 - m_bp;
    for (int i = 0; i < 4; i++) m_cur[i] = nc[i];
    @(posedge clk);
    #1;
    chk("R5 rdata", rdata, m_rdata);
    chk("R8 tc flags", stat_data[3:0], m_tc);
    chk("R10 request bits", stat_data[7:4], hw_req | sw_req);
    chk("R6 addr_out", addr_out, m_cur[xfer_ch]);
  endtask

  task automatic idle();
    {mclr, bp_clr, wr_en, rd_en, xfer, tc, stat_rd} = '0;
  endtask

  task automatic wr(input logic [1:0] ch, input logic [7:0] d);
    idle(); wr_en = 1; chan_sel = ch; wdata = d; tick(); idle();
  endtask

  task automatic rd(input logic [1:0] ch);
    idle(); rd_en = 1; chan_sel = ch; tick(); idle();
  endtask

  task automatic xf(input logic [1:0] ch, input logic t);
    idle(); xfer = 1; xfer_ch = ch; tc = t; tick(); idle();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin m_cur[i] = 0; m_base[i] = 0; end
    m_bp = 0; m_tc = 0; m_rdata = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset stat", stat_data, 0);
    chk("R1 reset rdata", rdata, 0);
    chk("R1 reset addr", addr_out, 0);
    rst_n = 1;
    rd(2'd3);
    chk("R1 reset low byte ch3", rdata, 8'h00);

    // R2 R4 R5: program ch1 and read it back
    idle(); bp_clr = 1; tick(); idle();
    wr(2'd1, 8'h34); wr(2'd1, 8'h12);
    rd(2'd1); chk("R2 low byte first", rdata, 8'h34);
    rd(2'd1); chk("R2 high byte second", rdata, 8'h12);

    // R3: clear mid-sequence
    rd(2'd1); idle(); bp_clr = 1; tick(); idle();
    rd(2'd1); chk("R3 clear returns to low byte", rdata, 8'h34);
    idle(); mclr = 1; tick(); idle();
    rd(2'd1); chk("R3 mclr returns to low byte", rdata, 8'h34);
    rd(2'd1);

    // R6: decrement wrap on ch0 (still 0000h)
    dir_dec = 4'b0001; xfer_ch = 2'd0;
    xf(2'd0, 1'b0); chk("R6 decrement wrap", addr_out, 16'hFFFF);
    xf(2'd0, 1'b0); chk("R6 decrement step", addr_out, 16'hFFFE);
    dir_dec = 4'b0000;
    xf(2'd0, 1'b0); xf(2'd0, 1'b0); xf(2'd0, 1'b0);
    chk("R6 increment wrap", addr_out, 16'h0001);

    // R7 R4: ch1 base 1234h steps then reloads at TC
    auto_init = 4'b0010; xfer_ch = 2'd1;
    xf(2'd1, 1'b0); xf(2'd1, 1'b0);
    chk("R6 increment ch1", addr_out, 16'h1236);
    xf(2'd1, 1'b1);
    chk("R7 auto-init reload", addr_out, 16'h1234);
    chk("R8 tc flag ch1", stat_data[3:0], 4'b0010);
    auto_init = 4'b0000;
    xf(2'd1, 1'b1);
    chk("R7 no auto-init steps", addr_out, 16'h1235);
    rd(2'd1); rd(2'd1); chk("R4 base unchanged via reload", rdata, 8'h12);

    // R9: status read clears, same-cycle tc survives
    idle(); stat_rd = 1; tick(); idle();
    chk("R9 read clears", stat_data[3:0], 0);
    idle(); xf(2'd2, 1'b1);
    idle(); stat_rd = 1; xfer = 1; xfer_ch = 2'd3; tc = 1; tick(); idle();
    chk("R9 same-cycle tc kept", stat_data[3:0], 4'b1000);
    idle(); mclr = 1; xfer = 1; xfer_ch = 2'd0; tc = 1; tick(); idle();
    chk("R9 mclr clears", stat_data[3:0], 0);

    // R10: live requests
    hw_req = 4'b0101; sw_req = 4'b1000; #1;
    chk("R10 live request", stat_data[7:4], 4'b1101);
    hw_req = 0; sw_req = 0;

    // R11: write and transfer same channel
    xfer_ch = 2'd2;
    idle(); bp_clr = 1; tick(); idle();
    idle(); wr_en = 1; chan_sel = 2'd2; wdata = 8'hAA;
    xfer = 1; xfer_ch = 2'd2; tc = 1; tick(); idle();
    chk("R11 write wins", addr_out[7:0], 8'hAA);
    chk("R11 tc still flagged", stat_data[2], 1);

    // R12: addr_out follows xfer_ch
    xfer_ch = 2'd1; #1;
    chk("R12 addr_out mux", addr_out, m_cur[1]);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      int op;
      idle();
      op = $urandom % 8;
      chan_sel = 2'($urandom);
      wdata = 8'($urandom);
      if (op < 3) wr_en = 1;
      else if (op < 5) rd_en = 1;
      bp_clr = ($urandom % 10) == 0;
      mclr = ($urandom % 40) == 0;
      xfer = ($urandom % 2) == 0;
      xfer_ch = 2'($urandom);
      tc = ($urandom % 6) == 0;
      stat_rd = ($urandom % 5) == 0;
      if (($urandom % 16) == 0) begin
        dir_dec = 4'($urandom); auto_init = 4'($urandom);
      end
      hw_req = 4'($urandom); sw_req = 4'($urandom) & 4'($urandom);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule